// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Status Flags

This block is an 18-bit first-in first-out buffer whose write port and read port each run on their own clock. The two clocks may be unrelated or may be one and the same net. Storage is an inferred register array whose depth is set by a parameter. Pointers pass between the two clock domains as Gray codes through a chain of flip-flops. A flip-flop chain of two or three stages is selected by a parameter.

A build-time parameter picks the read timing. In standard timing a word reaches `dout` only after a read-enabled read-clock edge, and the two main flags mean empty and full. In first-word-fall-through timing the oldest word is placed on `dout` without any request. The same two flags then mean output-ready and input-ready.

Three more flags are provided: half-full, almost-empty and almost-full. The two almost thresholds come from an offset pair that resets to 7 words each. The pair can be rewritten over the write port.

Top module: `dcfifo_flags`

## Requirements
- R1: Words leave the FIFO in the order they were accepted, with all 18 bits intact. Depth is the parameter `DEPTH` (256, 512, 1024, 2048 or 4096).
- R2: In standard timing, `ef_or` is 1 while no word is stored. `dout` changes only on a read-clock edge where `ren` was 1 and `ef_or` was 0, and it then shows the oldest word. A read while `ef_or` is 1 leaves `dout` and the read pointer unchanged.
- R3: In first-word-fall-through timing, the oldest word appears on `dout` with no read request, and `ef_or` is 1 while `dout` holds an unread word. `ren` at a read-clock edge consumes that word. `ff_ir` is 1 while the array has space, so the FIFO accepts `DEPTH`+1 words (array plus output register) before `ff_ir` falls.
- R4: In standard timing, `ff_ir` is 1 once `DEPTH` words are stored. A write while `ff_ir` is 1 is dropped and does not disturb stored data.
- R5: `hf` is 1 when the stored word count is greater than `DEPTH`/2.
- R6: `pae` is 1 when the stored word count is less than or equal to the empty offset.
- R7: `paf` is 1 when the stored word count is greater than or equal to `DEPTH` minus the full offset.
- R8: While `ld` and `wen` are both 1, write-clock edges load offsets from `din[log2(DEPTH)-1:0]`. The first such edge loads the empty offset and the next loads the full offset. These edges store no data. Dropping `ld` returns the loader to the empty offset.
- R9: A low `rst_n` empties the FIFO, clears both pointers and restores both offsets to 7.
- R10: Each pointer crosses between domains as a Gray code that changes by at most one bit per clock. The FIFO works both with unrelated clocks and with one shared clock.
- R11: With `DOUBLE_SYNC`=1 each crossing uses three flip-flop stages instead of two, with no change in data behaviour.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Active-low reset for both domains |
| wen | input | 1 | Write enable |
| ld | input | 1 | Offset-load select; with `wen` writes offsets instead of data |
| din | input | 18 | Write data / offset value |
| ren | input | 1 | Read enable |
| dout | output | 18 | Read data register |
| ef_or | output | 1 | Empty (standard) or output-ready (fall-through) |
| ff_ir | output | 1 | Full (standard) or input-ready (fall-through) |
| hf | output | 1 | Half-full flag (write domain) |
| pae | output | 1 | Almost-empty flag (read domain) |
| paf | output | 1 | Almost-full flag (write domain) |

## Verification
The assertions assume that both clocks run freely and that `rst_n` is held low across several edges of the slower clock. They also assume the offsets are changed only while the FIFO is idle, because the empty offset is read in the other domain without synchronisation. The stimulus releases reset away from every clock edge and loads offsets only with no traffic in flight. It waits a fixed settling time before sampling any flag that depends on the opposite domain. It writes while full and reads while empty on purpose, because the design must absorb those requests.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FWFT = 1'b1
    } dcf_mode_e;

    localparam int PTR_MAX = 16;

    function automatic logic [PTR_MAX-1:0] bin2gray(input logic [PTR_MAX-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [PTR_MAX-1:0] gray2bin(input logic [PTR_MAX-1:0] g);
        logic [PTR_MAX-1:0] b;
        b[PTR_MAX-1] = g[PTR_MAX-1];
        for (int i = PTR_MAX - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
    parameter int WIDTH  = 9,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[s] <= '0;
            end else begin
                stage_q[s] <= (s == 0) ? d : stage_q[(s == 0) ? 0 : s - 1];
            end
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/dcf_wr.sv
module dcf_wr
    import dcf_pkg::*;
#(
    parameter int DEPTH  = 256,
    parameter int AE_DEF = 7,
    parameter int AF_DEF = 7,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wen,
    input  logic          ld,
    input  logic [AW-1:0] off_in,
    input  logic [PW-1:0] rgray_s,
    output logic          mem_we,
    output logic [AW-1:0] waddr,
    output logic [PW-1:0] wgray,
    output logic          full,
    output logic          hf,
    output logic          paf,
    output logic [AW-1:0] ae_off
);
    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        logic          full;
        logic          hf;
        logic          paf;
        logic          sel;
        logic [AW-1:0] ae;
        logic [AW-1:0] af;
    } wr_st_t;

    wr_st_t        st_d, st_q;
    logic [PW-1:0] rbin_s;
    logic [PW-1:0] cnt_d;
    logic          wr_ok;
    logic          ld_ok;

    always_comb begin
        rbin_s   = PW'(gray2bin(PTR_MAX'(rgray_s)));
        wr_ok    = wen && !ld && !st_q.full;
        ld_ok    = wen && ld;
        st_d     = st_q;
        st_d.bin = st_q.bin + PW'(wr_ok);
        st_d.gray = PW'(bin2gray(PTR_MAX'(st_d.bin)));
        cnt_d     = st_d.bin - rbin_s;
        st_d.full = (cnt_d == PW'(DEPTH));
        st_d.hf   = (cnt_d > PW'(DEPTH / 2));
        st_d.paf  = (cnt_d >= (PW'(DEPTH) - PW'(st_q.af)));
        if (ld_ok) begin
            if (!st_q.sel) st_d.ae = off_in;
            else           st_d.af = off_in;
            st_d.sel = !st_q.sel;
        end else if (!ld) begin
            st_d.sel = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.ae   <= AW'(AE_DEF);
            st_q.af   <= AW'(AF_DEF);
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_we = wr_ok;
    assign waddr  = st_q.bin[AW-1:0];
    assign wgray  = st_q.gray;
    assign full   = st_q.full;
    assign hf     = st_q.hf;
    assign paf    = st_q.paf;
    assign ae_off = st_q.ae;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.bin - rbin_s) <= PW'(DEPTH)); // R4
    AST_FULL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.full && wen && !ld) |=> (st_q.bin == $past(st_q.bin))); // R4
    AST_WGRAY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(st_q.gray ^ $past(st_q.gray)) <= 1); // R10
endmodule

// File: rtl/dcf_rd.sv
module dcf_rd
    import dcf_pkg::*;
#(
    parameter int        DEPTH  = 256,
    parameter int        DATA_W = 18,
    parameter dcf_mode_e MODE   = MODE_STD,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ren,
    input  logic [PW-1:0]     wgray_s,
    input  logic [DATA_W-1:0] rdata,
    input  logic [AW-1:0]     ae_off,
    output logic [AW-1:0]     raddr,
    output logic [PW-1:0]     rgray,
    output logic [DATA_W-1:0] dout,
    output logic              ef_or,
    output logic              pae
);
    typedef struct packed {
        logic [PW-1:0]     bin;
        logic [PW-1:0]     gray;
        logic              empty;
        logic              valid;
        logic              pae;
        logic [DATA_W-1:0] dout;
    } rd_st_t;

    rd_st_t        st_d, st_q;
    logic [PW-1:0] wbin_s;
    logic [PW-1:0] cnt_d;
    logic          take;

    always_comb begin
        wbin_s = PW'(gray2bin(PTR_MAX'(wgray_s)));
        st_d   = st_q;
        if (MODE == MODE_STD) begin
            take = ren && !st_q.empty;
        end else begin
            take       = !st_q.empty && (!st_q.valid || ren);
            st_d.valid = take || (st_q.valid && !ren);
        end
        if (take) st_d.dout = rdata;
        st_d.bin   = st_q.bin + PW'(take);
        st_d.gray  = PW'(bin2gray(PTR_MAX'(st_d.bin)));
        cnt_d      = wbin_s - st_d.bin;
        st_d.empty = (cnt_d == '0);
        st_d.pae   = ((cnt_d + PW'(st_d.valid)) <= PW'(ae_off));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.empty <= 1'b1;
            st_q.pae   <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign raddr = st_q.bin[AW-1:0];
    assign rgray = st_q.gray;
    assign dout  = st_q.dout;
    assign ef_or = (MODE == MODE_STD) ? st_q.empty : st_q.valid;
    assign pae   = st_q.pae;

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (wbin_s - st_q.bin) <= PW'(DEPTH)); // R2
    AST_STD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (MODE == MODE_STD && !ren) |=> $stable(st_q.dout)); // R2
    AST_FWFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (MODE == MODE_FWFT && st_q.valid && !ren) |=> ($stable(st_q.dout) && st_q.valid)); // R3
    AST_RGRAY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(st_q.gray ^ $past(st_q.gray)) <= 1); // R10
endmodule

// File: rtl/dcfifo_flags.sv
module dcfifo_flags
    import dcf_pkg::*;
#(
    parameter int        DEPTH       = 256,
    parameter int        DATA_W      = 18,
    parameter dcf_mode_e MODE        = MODE_STD,
    parameter bit        DOUBLE_SYNC = 1'b0,
    parameter int        AE_DEF      = 7,
    parameter int        AF_DEF      = 7
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              rst_n,
    input  logic              wen,
    input  logic              ld,
    input  logic [DATA_W-1:0] din,
    input  logic              ren,
    output logic [DATA_W-1:0] dout,
    output logic              ef_or,
    output logic              ff_ir,
    output logic              hf,
    output logic              pae,
    output logic              paf
);
    localparam int AW     = $clog2(DEPTH);
    localparam int PW     = AW + 1;
    localparam int STAGES = DOUBLE_SYNC ? 3 : 2;

    logic [DATA_W-1:0] mem [DEPTH];
    logic              mem_we;
    logic [AW-1:0]     waddr, raddr, ae_off;
    logic [PW-1:0]     wgray, rgray, wgray_s, rgray_s;
    logic              full;

    always_ff @(posedge wclk) begin
        if (mem_we) mem[waddr] <= din;
    end

    dcf_wr #(.DEPTH(DEPTH), .AE_DEF(AE_DEF), .AF_DEF(AF_DEF)) i_wr (
        .clk(wclk), .rst_n(rst_n), .wen(wen), .ld(ld), .off_in(din[AW-1:0]),
        .rgray_s(rgray_s), .mem_we(mem_we), .waddr(waddr), .wgray(wgray),
        .full(full), .hf(hf), .paf(paf), .ae_off(ae_off)
    );

    dcf_sync #(.WIDTH(PW), .STAGES(STAGES)) i_sync_w2r (
        .clk(rclk), .rst_n(rst_n), .d(wgray), .q(wgray_s)
    );

    dcf_sync #(.WIDTH(PW), .STAGES(STAGES)) i_sync_r2w (
        .clk(wclk), .rst_n(rst_n), .d(rgray), .q(rgray_s)
    );

    dcf_rd #(.DEPTH(DEPTH), .DATA_W(DATA_W), .MODE(MODE)) i_rd (
        .clk(rclk), .rst_n(rst_n), .ren(ren), .wgray_s(wgray_s),
        .rdata(mem[raddr]), .ae_off(ae_off), .raddr(raddr), .rgray(rgray),
        .dout(dout), .ef_or(ef_or), .pae(pae)
    );

    assign ff_ir = (MODE == MODE_STD) ? full : !full;
endmodule

// File: tb/test_dcfifo_flags.sv
`timescale 1ns/100ps
module test_dcfifo_flags;
    import dcf_pkg::*;

    localparam int DEPTH = 256;
    localparam int DW    = 18;

    logic s_wclk = 0, s_rclk = 0, s_rst_n = 0;
    logic s_wen = 0, s_ld = 0, s_ren = 0;
    logic [DW-1:0] s_din = '0, s_dout;
    logic s_ef, s_ff, s_hf, s_pae, s_paf;

    logic f_rst_n = 0, f_wen = 0, f_ren = 0;
    logic [DW-1:0] f_din = '0, f_dout;
    logic f_or, f_ir, f_hf, f_pae, f_paf;

    int n_chk = 0, n_err = 0;
    logic [DW-1:0] sq[$];
    logic [DW-1:0] fq[$];
    logic [DW-1:0] seq = 18'h00100;

    always #4   s_wclk = ~s_wclk;
    always #5.5 s_rclk = ~s_rclk;

    dcfifo_flags #(.DEPTH(DEPTH), .MODE(MODE_STD), .DOUBLE_SYNC(1'b0)) i_dcfifo_flags (
        .wclk(s_wclk), .rclk(s_rclk), .rst_n(s_rst_n), .wen(s_wen), .ld(s_ld),
        .din(s_din), .ren(s_ren), .dout(s_dout), .ef_or(s_ef), .ff_ir(s_ff),
        .hf(s_hf), .pae(s_pae), .paf(s_paf)
    );

    dcfifo_flags #(.DEPTH(DEPTH), .MODE(MODE_FWFT), .DOUBLE_SYNC(1'b1)) i_dcfifo_flags_fwft (
        .wclk(s_wclk), .rclk(s_wclk), .rst_n(f_rst_n), .wen(f_wen), .ld(1'b0),
        .din(f_din), .ren(f_ren), .dout(f_dout), .ef_or(f_or), .ff_ir(f_ir),
        .hf(f_hf), .pae(f_pae), .paf(f_paf)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    task automatic settle();
        repeat (8) @(negedge s_rclk);
    endtask

    // driver: pushes every word the FIFO is expected to accept
    task automatic s_write(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge s_wclk);
            s_wen = 1; s_din = seq;
            if (!s_ff) sq.push_back(seq);
            seq = seq + 1;
        end
        @(negedge s_wclk);
        s_wen = 0;
    endtask

    task automatic s_read(input string req);
        logic was_empty;
        @(negedge s_rclk);
        s_ren = 1; was_empty = s_ef;
        @(negedge s_rclk);
        s_ren = 0;
        if (!was_empty) begin
            if (sq.size() == 0) chk(req, s_dout, 32'hDEAD);
            else chk(req, s_dout, sq.pop_front());
        end
    endtask

    task automatic s_reset();
        @(negedge s_rclk); s_rst_n = 0;
        repeat (4) @(negedge s_rclk);
        sq.delete();
        s_rst_n = 1;
        settle();
    endtask

    initial begin
        #1_500_000;
        n_err++;
        $display("FAIL R1 watchdog act=running exp=finished");
        finish_run();
    end

    initial begin
        logic [DW-1:0] held;
        int acc;
        s_reset();
        // reset state
        chk("R9 ef", s_ef, 1); chk("R9 ff", s_ff, 0); chk("R5 hf", s_hf, 0);
        chk("R6 pae", s_pae, 1); chk("R7 paf", s_paf, 0);

        // standard timing: no fall-through, read-on-request
        s_write(1); held = sq[0]; settle();
        chk("R2 no early data", s_dout, 0);
        chk("R2 not empty", s_ef, 0);
        s_read("R2 read"); settle();
        chk("R2 empty again", s_ef, 1);
        @(negedge s_rclk); s_ren = 1; @(negedge s_rclk); s_ren = 0;
        chk("R2 empty read ignored", s_dout, held);
        s_write(1); settle();
        s_read("R2 pointer intact");

        // flag thresholds with defaults
        settle(); s_write(7); settle(); chk("R6 pae at 7", s_pae, 1);
        s_write(1); settle(); chk("R6 pae at 8", s_pae, 0);
        s_write(120); settle(); chk("R5 hf at 128", s_hf, 0);
        s_write(1); settle(); chk("R5 hf at 129", s_hf, 1);
        s_write(119); settle(); chk("R7 paf at 248", s_paf, 0);
        s_write(1); settle(); chk("R7 paf at 249", s_paf, 1);
        s_write(7); settle(); chk("R4 full", s_ff, 1);
        s_write(1); settle(); chk("R4 still full", s_ff, 1);
        chk("R4 queued", sq.size(), DEPTH);
        for (int i = 0; i < DEPTH; i++) s_read("R1 order");
        settle();
        chk("R4 dropped word absent", s_ef, 1);
        chk("R5 hf drained", s_hf, 0);

        // offset load: empty offset 3, full offset 250 (threshold 6)
        @(negedge s_wclk); s_ld = 1; s_wen = 1; s_din = 18'd3;
        @(negedge s_wclk); s_din = 18'd250;
        @(negedge s_wclk); s_ld = 0; s_wen = 0;
        settle(); chk("R8 load stores no data", s_ef, 1);
        s_write(3); settle(); chk("R8 pae at 3", s_pae, 1); chk("R8 paf at 3", s_paf, 0);
        s_write(1); settle(); chk("R8 pae at 4", s_pae, 0);
        s_write(1); settle(); chk("R8 paf at 5", s_paf, 0);
        s_write(1); settle(); chk("R8 paf at 6", s_paf, 1);
        for (int i = 0; i < 6; i++) s_read("R8 data");
        settle(); chk("R8 drained", s_ef, 1);

        // reset restores defaults
        s_write(3); settle();
        s_reset();
        chk("R9 ef after reset", s_ef, 1);
        s_write(7); settle(); chk("R9 default pae at 7", s_pae, 1);
        s_write(1); settle(); chk("R9 default pae at 8", s_pae, 0);
        for (int i = 0; i < 8; i++) s_read("R9 data");

        // random traffic on unrelated clocks
        fork
            begin
                for (int i = 0; i < 1500; i++) begin
                    @(negedge s_wclk);
                    s_wen = 1'($urandom % 2); s_din = seq;
                    if (s_wen && !s_ff) sq.push_back(seq);
                    seq = seq + 1;
                end
                @(negedge s_wclk); s_wen = 0;
            end
            begin
                bit pend = 0;
                for (int i = 0; i < 1500; i++) begin
                    @(negedge s_rclk);
                    if (pend) begin
                        if (sq.size() == 0) chk("R10 async", s_dout, 32'hDEAD);
                        else chk("R10 async", s_dout, sq.pop_front());
                    end
                    s_ren = 1'($urandom % 2);
                    pend = s_ren && !s_ef;
                end
                @(negedge s_rclk);
                if (pend) chk("R10 async", s_dout, sq.pop_front());
                s_ren = 0;
            end
        join
        settle();
        while (sq.size() > 0) s_read("R10 drain");
        settle(); chk("R10 empty at end", s_ef, 1);

        // fall-through instance, shared clock, three-stage crossing
        @(negedge s_wclk); f_rst_n = 1;
        repeat (8) @(negedge s_wclk);
        chk("R3 or after reset", f_or, 0); chk("R3 ir after reset", f_ir, 1);
        @(negedge s_wclk); f_wen = 1; f_din = 18'h0ABCD;
        @(negedge s_wclk); f_wen = 0;
        repeat (8) @(negedge s_wclk);
        chk("R3 output ready", f_or, 1);
        chk("R3 fell through", f_dout, 18'h0ABCD);
        @(negedge s_wclk); f_ren = 1;
        @(negedge s_wclk); f_ren = 0;
        repeat (8) @(negedge s_wclk);
        chk("R3 consumed", f_or, 0);
        acc = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge s_wclk);
            f_wen = f_ir; f_din = seq;
            if (f_ir) begin fq.push_back(seq); acc++; end
            seq = seq + 1;
        end
        @(negedge s_wclk); f_wen = 0;
        repeat (8) @(negedge s_wclk);
        chk("R3 capacity", acc, DEPTH + 1);
        chk("R3 not ready for input", f_ir, 0);
        for (int i = 0; i < 2000; i++) begin
            logic r;
            @(negedge s_wclk);
            r = 1'($urandom % 2);
            if (r && f_or) begin
                if (fq.size() == 0) chk("R11 order", f_dout, 32'hDEAD);
                else chk("R11 order", f_dout, fq.pop_front());
            end
            f_ren = r;
            f_wen = 1'($urandom % 2); f_din = seq;
            if (f_wen && f_ir) fq.push_back(seq);
            seq = seq + 1;
        end
        @(negedge s_wclk); f_wen = 0; f_ren = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge s_wclk);
            if (f_or) begin
                if (fq.size() == 0) chk("R11 drain", f_dout, 32'hDEAD);
                else chk("R11 drain", f_dout, fq.pop_front());
            end
            f_ren = f_or;
        end
        @(negedge s_wclk); f_ren = 0;
        repeat (8) @(negedge s_wclk);
        chk("R11 all delivered", fq.size(), 0);
        chk("R3 or after drain", f_or, 0);
        finish_run();
    end
endmodule